// File: doc/BRIEF.md
# Timer Channel Pin Controller with Edge Interrupt

This block manages the single I/O pin of one general-purpose timer channel. Software reaches it through a small 32-bit register bus with two registers: a mode register and a status register. Depending on the mode register, the pin is a software-controlled GPIO, or an input whose chosen edges set a sticky event flag. That flag drives one maskable interrupt line.

The pin input passes through a two-flop synchroniser. A one-flop history behind the synchroniser detects edges. Event flags stay set until software writes a one to them, and an edge that arrives in the same cycle as a clearing write is never lost. Only the channel-function field of the mode register is decoded for the counting, output-compare and PWM functions. None of those functions is implemented here.

Top module: `tpin_ctrl`

## Requirements
- R1: After reset, the mode register reads 0, the status event flags read 0, `pin_oe` is 0 and `irq` is 0.
- R2: The mode register sits at byte offset 0x0. It keeps the function select in bits [2:0], the pin drive control in bits [5:4], the interrupt enable in bit 8 and the capture-edge select in bits [17:16]. Every other bit reads 0, so writing 0xFFFFFFFF reads back as 0x00030137.
- R3: Drive control: when bit 5 is 1 and the function is not input capture, `pin_oe` is 1 and `pin_out` follows bit 4 (10 drives low, 11 drives high). When bit 5 is 0, `pin_oe` is 0.
- R4: When the function select is 1 (input capture), `pin_oe` is 0 whatever the drive bits hold.
- R5: The status register sits at byte offset 0xC. Its bit 8 returns the synchronised pin level in any mode. The level becomes visible after the second rising clock edge following a pin change.
- R6: The status event flag (bit 0) is set only when the function select is 1. Edge select 01 reacts to rising edges, 10 to falling edges and 11 to both; 00 reacts to none. The flag becomes visible after the third rising clock edge following the pin change.
- R7: Writing status bits [3:0] clears each flag written with 1. A flag written with 0 stays unchanged.
- R8: When an edge sets a flag in the same cycle that a status write clears it, the flag ends set.
- R9: `irq` is 1 exactly when the interrupt enable (mode bit 8) is 1 and any event flag is set. Clearing the enable masks `irq` but keeps the flags.
- R10: Reads of any offset other than 0x0 and 0xC return 0. Writes to those offsets change neither register. Status bits other than 8 and [3:0] read 0, and bits [3:1] are never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read is in progress |
| pin_in | input | 1 | Pin level from the pad, asynchronous |
| pin_out | output | 1 | Level driven onto the pin |
| pin_oe | output | 1 | Pin output driver enable |
| irq | output | 1 | Channel interrupt request, level-sensitive |

## Verification
The assertions take `bus_en`, `bus_we`, `bus_addr` and `bus_wdata` to be stable, valid levels on every clock edge after reset. They also take a register access to last exactly one cycle, so that a held write never counts as a second clearing write. The stimulus drives every bus signal and the pin on the falling clock edge and drops `bus_en` one cycle after raising it. It changes `pin_in` only when a new edge is wanted and leaves at least three cycles before the flag is sampled. The one exception is the deliberate collision, where a clearing write is timed to land in the same cycle as the flag update.

// File: rtl/tpin_pkg.sv
package tpin_pkg;

  localparam int unsigned BUS_W = 32;

  // channel function codes (mode bits [2:0])
  localparam logic [2:0] FN_CAPTURE = 3'd1;
  localparam logic [2:0] FN_COMPARE = 3'd2;
  localparam logic [2:0] FN_PWM     = 3'd3;
  localparam logic [2:0] FN_GPIO    = 3'd4;

  // field positions inside the mode word
  localparam int unsigned FN_LSB   = 0;
  localparam int unsigned DRV_LSB  = 4;
  localparam int unsigned IEN_BIT  = 8;
  localparam int unsigned EDGE_LSB = 16;

  // field positions inside the status word
  localparam int unsigned LVL_BIT  = 8;

  // register byte offsets
  localparam logic [3:0] MODE_OFS = 4'h0;
  localparam logic [3:0] STAT_OFS = 4'hC;

  typedef struct packed {
    logic [1:0] edge_sel;  // bit0 rising, bit1 falling
    logic       irq_en;
    logic [1:0] drive;     // [1] enable driver, [0] level
    logic [2:0] fn;
  } mode_t;

endpackage

// File: rtl/tpin_sync.sv
module tpin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  // STAGES synchroniser flops plus one history flop
  logic [STAGES:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-1:0], pin_i};
  end

  assign level_o = shift_q[STAGES-1];
  assign rise_o  =  shift_q[STAGES-1] & ~shift_q[STAGES];
  assign fall_o  = ~shift_q[STAGES-1] &  shift_q[STAGES];

  AST_RISE_IS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> (level_o && !$past(level_o)));                       // R5
  AST_FALL_IS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> (!level_o && $past(level_o)));                       // R6

endmodule

// File: rtl/tpin_evt.sv
module tpin_evt #(
  parameter int unsigned EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] set_i,
  input  logic [EVT_W-1:0] clr_i,
  output logic [EVT_W-1:0] flags_o
);
  for (genvar i = 0; i < EVT_W; i++) begin : g_flag
    logic flag_q;

    // a set in the same cycle as a clear takes priority
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (set_i[i]) flag_q <= 1'b1;
      else if (clr_i[i]) flag_q <= 1'b0;
    end

    assign flags_o[i] = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flags_o[i]);                                     // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[i] && !clr_i[i]) |=> flags_o[i]);                    // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flags_o[i]);                     // R7
  end

endmodule

// File: rtl/tpin_ctrl.sv
module tpin_ctrl
  import tpin_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned EVT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

  mode_t             mode_q;
  logic              level;
  logic              rise;
  logic              fall;
  logic              capture;
  logic              hit;
  logic              mode_wr;
  logic              stat_wr;
  logic [EVT_W-1:0]  evt_set;
  logic [EVT_W-1:0]  evt_clr;
  logic [EVT_W-1:0]  flags;
  logic              unused_wbits;

  assign mode_wr = bus_en && bus_we && (bus_addr == A_MODE);
  assign stat_wr = bus_en && bus_we && (bus_addr == A_STAT);

  // mode register: only the defined fields are stored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_wr) begin
      mode_q.fn       <= bus_wdata[FN_LSB +: 3];
      mode_q.drive    <= bus_wdata[DRV_LSB +: 2];
      mode_q.irq_en   <= bus_wdata[IEN_BIT];
      mode_q.edge_sel <= bus_wdata[EDGE_LSB +: 2];
    end
  end

  assign unused_wbits = ^{bus_wdata[31:18], bus_wdata[15:9], bus_wdata[7:6],
                          bus_wdata[3]};

  tpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (pin_in),
    .level_o (level),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  assign capture = (mode_q.fn == FN_CAPTURE);
  assign hit     = capture && ((mode_q.edge_sel[0] && rise) ||
                               (mode_q.edge_sel[1] && fall));
  assign evt_set = {{(EVT_W-1){1'b0}}, hit};
  assign evt_clr = stat_wr ? bus_wdata[EVT_W-1:0] : '0;

  tpin_evt #(.EVT_W(EVT_W)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (evt_set),
    .clr_i   (evt_clr),
    .flags_o (flags)
  );

  // pin drive: input capture keeps the driver off
  assign pin_oe  = mode_q.drive[1] && !capture;
  assign pin_out = pin_oe && mode_q.drive[0];

  assign irq = mode_q.irq_en && (|flags);

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      if (bus_addr == A_MODE) begin
        bus_rdata[FN_LSB +: 3]   = mode_q.fn;
        bus_rdata[DRV_LSB +: 2]  = mode_q.drive;
        bus_rdata[IEN_BIT]       = mode_q.irq_en;
        bus_rdata[EDGE_LSB +: 2] = mode_q.edge_sel;
      end else if (bus_addr == A_STAT) begin
        bus_rdata[EVT_W-1:0] = flags;
        bus_rdata[LVL_BIT]   = level;
      end
    end
  end

  AST_CAPTURE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.fn == FN_CAPTURE) |-> !pin_oe);                         // R4
  AST_MASKED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q.irq_en |-> !irq);                                       // R9
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));                                         // R9
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(mode_q));                                  // R10
  AST_UPPER_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    flags[EVT_W-1:1] == '0);                                        // R10

endmodule

// File: tb/sim_tpin_ctrl.sv
`timescale 1ns/1ps
module sim_tpin_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pin_in = 1'b0;
  logic        pin_out;
  logic        pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;   // 125 MHz

  tpin_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk);
    pin_in = v;
  endtask

  // change the pin and wait until the flag has had time to settle
  task automatic pin_settle(input logic v);
    set_pin(v);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'h0, d);  chk("R1 mode after reset", d, 32'h0);
    rd(4'hC, d);  chk("R1 flags after reset", d & 32'hF, 32'h0);
    chk("R1 pin_oe after reset", {31'b0, pin_oe}, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mode_fields;
    logic [31:0] d;
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d);  chk("R2 mode readback all ones", d, 32'h0003_0137);
    wr(4'h0, 32'h0001_0104);
    rd(4'h0, d);  chk("R2 mode readback pattern", d, 32'h0001_0104);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_gpio_drive;
    wr(4'h0, 32'h34); @(negedge clk);
    chk("R3 drive high oe", {31'b0, pin_oe}, 32'h1);
    chk("R3 drive high level", {31'b0, pin_out}, 32'h1);
    wr(4'h0, 32'h24); @(negedge clk);
    chk("R3 drive low oe", {31'b0, pin_oe}, 32'h1);
    chk("R3 drive low level", {31'b0, pin_out}, 32'h0);
    wr(4'h0, 32'h04); @(negedge clk);
    chk("R3 input no drive", {31'b0, pin_oe}, 32'h0);
  endtask

  task automatic t_capture_no_drive;
    wr(4'h0, 32'h31); @(negedge clk);
    chk("R4 capture blocks driver", {31'b0, pin_oe}, 32'h0);
    wr(4'h0, 32'h04);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(4'h0, 32'h04);
    set_pin(1'b1);
    rd(4'hC, d);  chk("R5 level not yet after one edge", {31'b0, d[8]}, 32'h0);
    rd(4'hC, d);  chk("R5 level after two edges", {31'b0, d[8]}, 32'h1);
    chk("R6 no event outside capture", d & 32'hF, 32'h0);
    pin_settle(1'b0);
    rd(4'hC, d);  chk("R5 level low", {31'b0, d[8]}, 32'h0);
  endtask

  task automatic t_rise_latency;
    logic [31:0] d;
    wr(4'hC, 32'hF);
    wr(4'h0, 32'h0001_0001);
    set_pin(1'b1);
    rd(4'hC, d);
    rd(4'hC, d);  chk("R6 flag not yet after two edges", d & 32'hF, 32'h0);
    rd(4'hC, d);  chk("R6 rising flag after three edges", d & 32'hF, 32'h1);
    wr(4'hC, 32'hF);
    pin_settle(1'b0);
    rd(4'hC, d);  chk("R6 rising mode ignores fall", d & 32'hF, 32'h0);
  endtask

  task automatic t_edge_modes;
    logic [31:0] d;
    // falling only
    wr(4'h0, 32'h0002_0001);
    pin_settle(1'b1);
    rd(4'hC, d);  chk("R6 falling mode ignores rise", d & 32'hF, 32'h0);
    pin_settle(1'b0);
    rd(4'hC, d);  chk("R6 falling mode sets flag", d & 32'hF, 32'h1);
    wr(4'hC, 32'h1);
    // both
    wr(4'h0, 32'h0003_0001);
    pin_settle(1'b1);
    rd(4'hC, d);  chk("R6 toggle mode rise", d & 32'hF, 32'h1);
    wr(4'hC, 32'h1);
    pin_settle(1'b0);
    rd(4'hC, d);  chk("R6 toggle mode fall", d & 32'hF, 32'h1);
    wr(4'hC, 32'h1);
    // none
    wr(4'h0, 32'h0000_0001);
    pin_settle(1'b1);
    pin_settle(1'b0);
    rd(4'hC, d);  chk("R6 no edge selected", d & 32'hF, 32'h0);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr(4'h0, 32'h0001_0001);
    pin_settle(1'b1);
    wr(4'hC, 32'hE);
    rd(4'hC, d);  chk("R7 writing zero keeps flag", d & 32'hF, 32'h1);
    chk("R10 upper flags never set", d & 32'hE, 32'h0);
    wr(4'hC, 32'h1);
    rd(4'hC, d);  chk("R7 writing one clears flag", d & 32'hF, 32'h0);
    pin_settle(1'b0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    wr(4'h0, 32'h0001_0001);
    wr(4'hC, 32'hF);
    set_pin(1'b1);
    @(negedge clk);
    wr(4'hC, 32'h1);     // write lands on the same edge as the flag set
    rd(4'hC, d);  chk("R8 set beats clear", d & 32'hF, 32'h1);
    wr(4'hC, 32'h1);
    pin_settle(1'b0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(4'hC, 32'hF);
    wr(4'h0, 32'h0001_0101);
    @(negedge clk);
    chk("R9 no irq without flag", {31'b0, irq}, 32'h0);
    pin_settle(1'b1);
    chk("R9 irq on flag", {31'b0, irq}, 32'h1);
    wr(4'h0, 32'h0001_0001);
    @(negedge clk);
    chk("R9 masked irq", {31'b0, irq}, 32'h0);
    rd(4'hC, d);  chk("R9 mask keeps flag", d & 32'hF, 32'h1);
    wr(4'h0, 32'h0001_0101);
    @(negedge clk);
    chk("R9 unmask restores irq", {31'b0, irq}, 32'h1);
    wr(4'hC, 32'h1);
    @(negedge clk);
    chk("R9 irq drops after clear", {31'b0, irq}, 32'h0);
    pin_settle(1'b0);
  endtask

  task automatic t_unused;
    logic [31:0] d;
    wr(4'h0, 32'h0001_0001);
    pin_settle(1'b1);
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h4, d);  chk("R10 offset 4 reads zero", d, 32'h0);
    rd(4'h8, d);  chk("R10 offset 8 reads zero", d, 32'h0);
    rd(4'h0, d);  chk("R10 mode untouched", d, 32'h0001_0001);
    rd(4'hC, d);  chk("R10 status untouched", d, 32'h0000_0101);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode_fields();
    t_gpio_drive();
    t_capture_no_drive();
    t_level();
    t_rise_latency();
    t_edge_modes();
    t_w1c();
    t_set_wins();
    t_irq();
    t_unused();
    summary();
    $finish;
  end

endmodule